// File: doc/BRIEF.md
# Byte-Wide Parallel Flash Bus Front-End

This block sits between the external pins of a byte-wide parallel flash device and its internal command logic. It samples the three active-low bus controls (chip select, output gate and write strobe) into the internal clock domain. From them it decodes one of four bus modes: read, write, output-disable or standby. It drives the data bus only during a read and leaves it released in every other mode.

A read normally returns a byte from a small behavioural storage array. When the high-voltage identification flag is raised during a read, the block returns an identification code instead, or the protection state of one of eight address blocks. Which of these it returns depends on three low address pins.

A write is taken under either write-strobe or chip-select control. The address is captured when the second of the two strobes goes active. The data is captured when the first of them goes inactive. One clock later the captured pair is offered to the command interface as a single-cycle strobe. The same strobe also programs the behavioural array by clearing bits, unless the target block is protected. A test port sets and clears the per-block protection bits.

Top module: `pflash_front`

## Requirements
- R1: With ce_n=0, oe_n=0 and we_n=1 held stable, dq_oe is 1 and dq_o carries the read byte within 3 clock cycles. All pin inputs pass through a two-stage synchronizer.
- R2: With ce_n=0, oe_n=1 and we_n=0 (write mode), dq_oe is 0.
- R3: With ce_n=1 (standby, any oe_n/we_n), or with ce_n=0 and both oe_n and we_n high (output disable), dq_oe is 0.
- R4: In a read with hv_id=1, addr bits {6,1,0}=000 returns 8'h20 and {6,1,0}=001 returns 8'hE2. All other address bits have no effect on these two codes.
- R5: In a read with hv_id=1 and addr bits {6,1,0}=010, dq_o is 8'h01 if the block selected by addr[18:16] is protected and 8'h00 otherwise. Any other combination of bits {6,1,0} with hv_id=1 returns 8'h00.
- R6: In a write-strobe-controlled write (ce_n held low), cmd_addr is the address present when we_n fell, and cmd_data is the byte present when we_n rose.
- R7: In a chip-select-controlled write (we_n held low), cmd_addr is the address present when ce_n fell, and cmd_data is the byte present when ce_n rose.
- R8: Each write produces exactly one cmd_valid pulse, one clock cycle wide, issued one cycle after the data is captured.
- R9: After reset, cmd_valid is 0, every block is unprotected and every array byte reads 8'hFF.
- R10: A prot_set pulse marks block prot_blk protected and a prot_clr pulse unprotects it. When both are pulsed in the same cycle, the set wins.
- R11: A read with hv_id=0 returns the array byte at addr[3:0]. Programming clears bits, so the stored byte becomes the old value AND the written byte.
- R12: A write whose cmd_addr[18:16] names a protected block still issues its cmd_valid strobe but leaves the array byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| we_n | input | 1 | Write strobe, active low |
| hv_id | input | 1 | High-voltage identification flag |
| addr | input | 19 | Byte address pins |
| dq_i | input | 8 | Data bus as seen on the pins |
| dq_o | output | 8 | Data to drive onto the bus |
| dq_oe | output | 1 | Bus drive enable; 0 means high impedance |
| cmd_valid | output | 1 | Single-cycle command strobe |
| cmd_addr | output | 19 | Captured write address |
| cmd_data | output | 8 | Captured write byte |
| prot_set | input | 1 | Test port: protect block prot_blk |
| prot_clr | input | 1 | Test port: unprotect block prot_blk |
| prot_blk | input | 3 | Test port: block index |

## Verification
The hardest case to reach from the ports is a write whose address and data come from two different edges. This matters most when the two strobes take turns: under chip-select control the write strobe goes low first, and the address must still be taken when chip select falls. The bench drives both orderings. After each capturing edge it changes the address pins to a decoy value, so a latch that sampled at the wrong moment reports the decoy. It also programs the same byte twice to expose bit clearing, and it writes into a block while that block is protected.

// File: rtl/pff_pkg.sv
package pff_pkg;

  typedef enum logic [1:0] {
    BUS_STANDBY = 2'd0,
    BUS_QUIET   = 2'd1,
    BUS_READ    = 2'd2,
    BUS_WRITE   = 2'd3
  } bus_mode_e;

  // Decode of the three active-low controls; an illegal both-low
  // combination is treated as quiet (no drive, no write).
  function automatic bus_mode_e decode_bus(input logic ce_n,
                                           input logic oe_n,
                                           input logic we_n);
    bus_mode_e m;
    if (ce_n)                m = BUS_STANDBY;
    else if (!oe_n && we_n)  m = BUS_READ;
    else if (oe_n && !we_n)  m = BUS_WRITE;
    else                     m = BUS_QUIET;
    return m;
  endfunction

endpackage

// File: rtl/pff_sync.sv
module pff_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st1_q;
  logic [W-1:0] st2_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1_q[i] <= RST_VAL[i];
        st2_q[i] <= RST_VAL[i];
      end else begin
        st1_q[i] <= d[i];
        st2_q[i] <= st1_q[i];
      end
    end
  end

  assign q = st2_q;
endmodule

// File: rtl/pff_wlatch.sv
module pff_wlatch #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_act,
  input  logic [AW-1:0] addr_s,
  input  logic [DW-1:0] data_s,
  output logic          cmd_valid,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data
);
  logic          act_q, act_d;
  logic          pend_q, pend_d;
  logic          vld_q, vld_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic          start, stop;

  always_comb begin
    start  = wr_act && !act_q;
    stop   = !wr_act && act_q;
    act_d  = wr_act;
    addr_d = start ? addr_s : addr_q;
    data_d = stop ? data_s : data_q;
    pend_d = stop;
    vld_d  = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      act_q  <= act_d;
      pend_q <= pend_d;
      vld_q  <= vld_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign cmd_valid = vld_q;
  assign cmd_addr  = addr_q;
  assign cmd_data  = data_q;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && wr_act) |=> $stable(addr_q)) else $error("address moved mid-write"); // R6

  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q) else $error("strobe wider than one cycle"); // R8

  AST_CMD_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> $past(pend_q)) else $error("strobe without capture"); // R8
endmodule

// File: rtl/pff_prot.sv
module pff_prot #(
  parameter int BLK_W = 3,
  localparam int NBLK = 1 << BLK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic [NBLK-1:0]  prot_o
);
  logic [NBLK-1:0] prot_q, prot_d;

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    always_comb begin
      prot_d[b] = prot_q[b];
      if (blk_i == BLK_W'(b)) begin
        if (set_i)      prot_d[b] = 1'b1;
        else if (clr_i) prot_d[b] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prot_q <= '0;
    else        prot_q <= prot_d;
  end

  assign prot_o = prot_q;

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> prot_q[$past(blk_i)]) else $error("set lost"); // R10

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !prot_q[$past(blk_i)]) else $error("clear lost"); // R10
endmodule

// File: rtl/pff_array.sv
module pff_array #(
  parameter int AW = 4,
  parameter int DW = 8,
  localparam int NWORD = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_blocked,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem_q [NWORD];

  for (genvar i = 0; i < NWORD; i++) begin : g_word
    logic [DW-1:0] nxt;
    always_comb begin
      nxt = mem_q[i];
      if (wr_en && !wr_blocked && (wr_idx == AW'(i)))
        nxt = mem_q[i] & wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[i] <= '1;
      else        mem_q[i] <= nxt;
    end
  end

  assign rd_data = mem_q[rd_idx];

  AST_BLOCKED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_blocked) |=> (mem_q[$past(wr_idx)] == $past(mem_q[wr_idx])))
    else $error("protected byte changed"); // R12

  AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((mem_q[$past(wr_idx)] & ~$past(mem_q[wr_idx])) == '0))
    else $error("bit set by programming"); // R11
endmodule

// File: rtl/pflash_front.sv
module pflash_front
  import pff_pkg::*;
#(
  parameter int         ADDR_W   = 19,
  parameter int         DATA_W   = 8,
  parameter int         BLK_W    = 3,
  parameter int         MEM_AW   = 4,
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'hE2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              hv_id,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              prot_set,
  input  logic              prot_clr,
  input  logic [BLK_W-1:0]  prot_blk
);
  localparam int NBLK  = 1 << BLK_W;
  localparam int BUS_W = ADDR_W + DATA_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // pin synchronisers; idle controls reset to inactive
  logic [3:0] ctl_s;
  pff_sync #(.W(4), .RST_VAL(4'b0111)) u_ctl_sync (
    .clk(clk), .rst_n(rst_int_n),
    .d({hv_id, we_n, oe_n, ce_n}), .q(ctl_s)
  );

  logic [BUS_W-1:0] bus_s;
  pff_sync #(.W(BUS_W), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_int_n),
    .d({addr, dq_i}), .q(bus_s)
  );

  logic              ce_s, oe_s, we_s, hv_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;
  assign {hv_s, we_s, oe_s, ce_s} = ctl_s;
  assign {addr_s, data_s}         = bus_s;

  bus_mode_e mode;
  logic      wr_act;
  always_comb begin
    mode   = decode_bus(ce_s, oe_s, we_s);
    wr_act = (mode == BUS_WRITE);
  end

  pff_wlatch #(.AW(ADDR_W), .DW(DATA_W)) u_wlatch (
    .clk(clk), .rst_n(rst_int_n), .wr_act(wr_act),
    .addr_s(addr_s), .data_s(data_s),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  logic [NBLK-1:0] prot_vec;
  pff_prot #(.BLK_W(BLK_W)) u_prot (
    .clk(clk), .rst_n(rst_int_n),
    .set_i(prot_set), .clr_i(prot_clr), .blk_i(prot_blk),
    .prot_o(prot_vec)
  );

  logic [DATA_W-1:0] arr_rd;
  logic              wr_blocked;
  assign wr_blocked = prot_vec[cmd_addr[ADDR_W-1 -: BLK_W]];

  pff_array #(.AW(MEM_AW), .DW(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(cmd_valid), .wr_blocked(wr_blocked),
    .wr_idx(cmd_addr[MEM_AW-1:0]), .wr_data(cmd_data),
    .rd_idx(addr_s[MEM_AW-1:0]), .rd_data(arr_rd)
  );

  // read source selection
  logic [DATA_W-1:0] id_byte;
  always_comb begin
    case ({addr_s[6], addr_s[1], addr_s[0]})
      3'b000:  id_byte = DATA_W'(MFR_CODE);
      3'b001:  id_byte = DATA_W'(DEV_CODE);
      3'b010:  id_byte = DATA_W'(prot_vec[addr_s[ADDR_W-1 -: BLK_W]]);
      default: id_byte = '0;
    endcase
  end

  assign dq_o  = hv_s ? id_byte : arr_rd;
  assign dq_oe = (mode == BUS_READ);

  AST_STANDBY_RELEASED: assert property (@(posedge clk) disable iff (!rst_int_n)
    ce_s |-> !dq_oe) else $error("bus driven in standby"); // R3

  AST_WRITE_RELEASED: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_act |-> !dq_oe) else $error("bus driven in write"); // R2

  AST_STROBE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmd_valid |-> !wr_act) else $error("strobe during active write"); // R8
endmodule

// File: tb/sim_pflash_front.sv
module sim_pflash_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, hv_id = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  dq_i = '0;
  logic [7:0]  dq_o;
  logic        dq_oe;
  logic        cmd_valid;
  logic [18:0] cmd_addr;
  logic [7:0]  cmd_data;
  logic        prot_set = 1'b0, prot_clr = 1'b0;
  logic [2:0]  prot_blk = '0;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  pflash_front u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .hv_id(hv_id), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .prot_set(prot_set), .prot_clr(prot_clr), .prot_blk(prot_blk)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_at(input logic hv, input logic [18:0] a, input logic [7:0] exp,
                         input string tag);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; hv_id = hv; addr = a;
    idle(4);
    check(dq_oe === 1'b1, tag, {31'd0, dq_oe}, 32'd1);
    check(dq_o === exp, tag, {24'd0, dq_o}, {24'd0, exp});
    ce_n = 1'b1; oe_n = 1'b1; hv_id = 1'b0;
    idle(3);
  endtask

  // look for the command strobe; expect one pulse of one cycle
  task automatic expect_cmd(input logic [18:0] ea, input logic [7:0] ed, input string tag);
    int width = 0;
    logic [18:0] ga = '0;
    logic [7:0]  gd = '0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (cmd_valid) begin
        if (width == 0) begin ga = cmd_addr; gd = cmd_data; end
        width++;
      end
    end
    check(width == 1, "R8 strobe width", width, 32'd1);
    check(ga === ea, tag, {13'd0, ga}, {13'd0, ea});
    check(gd === ed, tag, {24'd0, gd}, {24'd0, ed});
  endtask

  // write strobe controlled: ce_n low first, we_n carries the edges
  task automatic write_we(input logic [18:0] a, input logic [7:0] d, input string tag);
    oe_n = 1'b1; ce_n = 1'b0; addr = a; dq_i = 8'h00;
    idle(3);
    we_n = 1'b0;
    idle(3);
    addr = 19'h7FFFF; dq_i = d;  // decoy address after the capturing edge
    idle(3);
    check(dq_oe === 1'b0, "R2 no drive in write", {31'd0, dq_oe}, 32'd0);
    we_n = 1'b1;
    fork
      expect_cmd(a, d, tag);
      begin idle(3); dq_i = 8'hA5; end
    join
    ce_n = 1'b1;
    idle(3);
  endtask

  // chip select controlled: we_n low first, ce_n carries the edges
  task automatic write_ce(input logic [18:0] a, input logic [7:0] d, input string tag);
    oe_n = 1'b1; we_n = 1'b0; addr = a; dq_i = 8'h00;
    idle(3);
    ce_n = 1'b0;
    idle(3);
    addr = 19'h7FFFF; dq_i = d;
    idle(3);
    ce_n = 1'b1;
    fork
      expect_cmd(a, d, tag);
      begin idle(3); dq_i = 8'hA5; end
    join
    we_n = 1'b1;
    idle(3);
  endtask

  task automatic prot_pulse(input bit s, input bit c, input logic [2:0] b);
    prot_blk = b; prot_set = s; prot_clr = c;
    @(negedge clk);
    prot_set = 1'b0; prot_clr = 1'b0;
    idle(2);
  endtask

  // {ce_n, oe_n, we_n, hv_id, addr[18:0], exp_oe, exp_byte}
  localparam logic [31:0] VEC [8] = '{
    {4'b0010, 19'h00000, 1'b1, 8'hFF},  // R11 blank array
    {4'b0011, 19'h00000, 1'b1, 8'h20},  // R4 maker code
    {4'b0011, 19'h00001, 1'b1, 8'hE2},  // R4 part code
    {4'b0011, 19'h7FFBC, 1'b1, 8'h20},  // R4 other bits ignored
    {4'b0011, 19'h50002, 1'b1, 8'h00},  // R5 block 5 open
    {4'b0011, 19'h00040, 1'b1, 8'h00},  // R5 other select
    {4'b1001, 19'h00000, 1'b0, 8'h00},  // R3 standby
    {4'b0110, 19'h00000, 1'b0, 8'h00}   // R3 output disabled
  };

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    check(cmd_valid === 1'b0, "R9 strobe idle", {31'd0, cmd_valid}, 32'd0);
    check(dq_oe === 1'b0, "R3 idle bus", {31'd0, dq_oe}, 32'd0);

    foreach (VEC[k]) begin
      ce_n = VEC[k][31]; oe_n = VEC[k][30]; we_n = VEC[k][29];
      hv_id = VEC[k][28]; addr = VEC[k][27:9];
      idle(4);
      check(dq_oe === VEC[k][8], "R1/R3 vector drive", {31'd0, dq_oe}, {31'd0, VEC[k][8]});
      if (VEC[k][8])
        check(dq_o === VEC[k][7:0], "R1/R4/R5 vector data", {24'd0, dq_o}, {24'd0, VEC[k][7:0]});
    end
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; hv_id = 1'b0;
    idle(3);

    write_we(19'h00003, 8'h5A, "R6 we-controlled capture");
    read_at(1'b0, 19'h00003, 8'h5A, "R11 readback");
    write_ce(19'h00003, 8'h0F, "R7 ce-controlled capture");
    read_at(1'b0, 19'h00003, 8'h0A, "R11 bits only clear");

    prot_pulse(1'b1, 1'b0, 3'd2);
    read_at(1'b1, 19'h20002, 8'h01, "R5 block 2 protected");
    read_at(1'b1, 19'h50002, 8'h00, "R10 block 5 untouched");
    write_we(19'h20007, 8'h00, "R12 strobe still issued");
    read_at(1'b0, 19'h00007, 8'hFF, "R12 protected byte kept");

    prot_pulse(1'b0, 1'b1, 3'd2);
    read_at(1'b1, 19'h20002, 8'h00, "R10 cleared");
    prot_pulse(1'b1, 1'b1, 3'd4);
    read_at(1'b1, 19'h40002, 8'h01, "R10 set wins");
    write_ce(19'h20007, 8'h3C, "R7 second capture");
    read_at(1'b0, 19'h00007, 8'h3C, "R11 open block programs");

    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    check(cmd_valid === 1'b0, "R9 strobe after reset", {31'd0, cmd_valid}, 32'd0);
    read_at(1'b1, 19'h40002, 8'h00, "R9 protection cleared");
    read_at(1'b0, 19'h00003, 8'hFF, "R9 array erased");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule